// File: doc/BRIEF.md
# Transmit/Receive Keying Frequency Sequencer

This block decides which frequency a synthesizer loader should program as a key input opens and closes. It also orders each load request against the transmit-out indication. When the key closes, the transmit frequency is requested first. The transmit output rises only after the loader reports that the load is done. When the key opens, the transmit output falls first, and only then is the receive frequency requested. This ordering means the transmitter is never keyed while the synthesizer still holds the wrong frequency.

In CW mode the transmit frequency is shifted away from the tuned frequency by a user-set pitch. The selected sideband sets the sign of the shift. The sideband also chooses a quadrature phase of 90° or 270° between the two synthesizer outputs. In phone mode no shift is applied. With the receive-offset (RIT) option on, the transmit frequency comes from a separately held value, while the receive frequency follows the tuning dial. A sidetone enable follows the filtered key when the sidetone option is set.

The raw key is synchronised and debounced before it is used. A key change that arrives while a load is in progress is not lost. The sequencer acts on it after load-done, in the same ordered way.

The sequencer has five states:
- `ST_RX_IDLE`: receive, key open.
- `ST_TX_LOAD`: transmit frequency requested.
- `ST_TX_ON`: transmitting.
- `ST_UNKEY`: transmit output dropped, no request yet.
- `ST_RX_LOAD`: receive frequency requested.

The transitions are:
- `ST_RX_IDLE` to `ST_TX_LOAD` on a closed key.
- `ST_TX_LOAD` to `ST_TX_ON` on done with the key closed.
- `ST_TX_LOAD` to `ST_UNKEY` on done with the key open (queued release).
- `ST_TX_ON` to `ST_UNKEY` on an open key.
- `ST_UNKEY` to `ST_RX_LOAD` always.
- `ST_RX_LOAD` to `ST_RX_IDLE` on done.

A key that is still closed when `ST_RX_IDLE` is reached leads on to `ST_TX_LOAD` in the next cycle (queued close).

Top module: `txrx_key_seq`

## Requirements
- R1: After reset, `tx_out`, `load_req` and `sidetone_en` are 0 and the sequencer is in receive idle.
- R2: When the filtered key closes, `load_req` rises carrying the transmit frequency. `tx_out` stays 0 until `load_done` is seen with `load_req` high. `tx_out` goes to 1 in the following cycle, and `load_req` drops in that same cycle.
- R3: When the filtered key opens during transmit, `tx_out` falls one cycle before `load_req` rises with the receive frequency. `tx_out` and `load_req` are never high together.
- R4: In CW mode (`cw_mode`=1), the transmit frequency is the base frequency plus `cw_pitch` when `upper_sb`=1, and the base minus `cw_pitch` when `upper_sb`=0, taken modulo 2^FREQ_W.
- R5: In phone mode (`cw_mode`=0), the transmit frequency equals the base frequency with no shift.
- R6: `load_phase_270` is 1 when `upper_sb`=0 and 0 when `upper_sb`=1, captured together with `load_freq` when the request starts.
- R7: The transmit base is `tx_hold_freq` when `rit_on`=1 and `dial_freq` when `rit_on`=0. The receive frequency is always `dial_freq`.
- R8: `sidetone_en` is 1 exactly while the filtered key is closed and `sidetone_opt`=1.
- R9: A key change that lasts fewer than DEB_CYCLES consecutive synchronised samples has no effect: no load request and no sidetone.
- R10: A key release during a transmit load never raises `tx_out`. After `load_done`, the receive load follows. A key close during a receive load leads, after `load_done`, to a transmit load in the next cycle but one.
- R11: While `load_req` is high and `load_done` is low, `load_req`, `load_freq` and `load_phase_270` hold their values. `load_req` is low in the cycle after `load_done` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_raw | input | 1 | Raw key line, 1 = closed |
| cw_mode | input | 1 | 1 = CW (pitch shift), 0 = phone |
| upper_sb | input | 1 | 1 = upper sideband, 0 = lower sideband |
| rit_on | input | 1 | 1 = transmit frequency taken from the held value |
| dial_freq | input | FREQ_W | Tuned (receive) frequency |
| tx_hold_freq | input | FREQ_W | Held transmit frequency used when RIT is on |
| cw_pitch | input | PITCH_W | CW pitch offset |
| sidetone_opt | input | 1 | Sidetone option bit |
| load_done | input | 1 | Loader finished the current request |
| load_req | output | 1 | Request to program the synthesizer |
| load_freq | output | FREQ_W | Frequency to program |
| load_phase_270 | output | 1 | 1 = 270° quadrature phase, 0 = 90° |
| tx_out | output | 1 | Transmit indication |
| sidetone_en | output | 1 | Sidetone enable |

## Verification
A wrong state or a wrong transition shows up at the ports within one or two cycles of a key edge or of `load_done`. It appears as `tx_out` rising before the loader has answered, `load_req` overlapping `tx_out`, or a request that never drops. A wrong offset sign, base or phase choice appears as a wrong `load_freq` or `load_phase_270` in the very first cycle of the request. The bench sweeps every combination of mode, sideband and RIT over frequencies chosen to wrap past zero and past the top. It also drives key glitches and key changes during pending loads, to expose a debounce or queueing fault through the absence or presence of a request.

// File: rtl/txkey_pkg.sv
package txkey_pkg;
    typedef enum logic [2:0] {
        ST_RX_IDLE = 3'd0,
        ST_TX_LOAD = 3'd1,
        ST_TX_ON   = 3'd2,
        ST_UNKEY   = 3'd3,
        ST_RX_LOAD = 3'd4
    } seq_state_t;
endpackage

// File: rtl/key_filter.sv
module key_filter #(
    parameter int DEB_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_in,
    output logic key_lvl
);
    localparam int CW = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '0;
            cnt_q   <= '0;
            key_lvl <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], key_in};
            if (sync_q[1] == key_lvl) begin
                cnt_q <= '0;
            end else if (cnt_q == LAST) begin
                cnt_q   <= '0;
                key_lvl <= sync_q[1];
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/freq_pick.sv
module freq_pick #(
    parameter int FREQ_W  = 32,
    parameter int PITCH_W = 12
) (
    input  logic               want_tx,
    input  logic               cw_mode,
    input  logic               upper_sb,
    input  logic               rit_on,
    input  logic [FREQ_W-1:0]  dial_freq,
    input  logic [FREQ_W-1:0]  tx_hold_freq,
    input  logic [PITCH_W-1:0] cw_pitch,
    output logic [FREQ_W-1:0]  freq,
    output logic               phase_270
);
    logic [FREQ_W-1:0] base;
    logic [FREQ_W-1:0] shift;

    generate
        if (PITCH_W >= FREQ_W) begin : g_trunc
            assign shift = cw_pitch[FREQ_W-1:0];
        end else begin : g_ext
            assign shift = {{(FREQ_W-PITCH_W){1'b0}}, cw_pitch};
        end
    endgenerate

    always_comb begin
        base = rit_on ? tx_hold_freq : dial_freq;
        if (!want_tx)      freq = dial_freq;
        else if (!cw_mode) freq = base;
        else if (upper_sb) freq = base + shift;
        else               freq = base - shift;
        phase_270 = ~upper_sb;
    end
endmodule

// File: rtl/txrx_key_seq.sv
module txrx_key_seq
    import txkey_pkg::*;
#(
    parameter int FREQ_W     = 32,
    parameter int PITCH_W    = 12,
    parameter int DEB_CYCLES = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               key_raw,
    input  logic               cw_mode,
    input  logic               upper_sb,
    input  logic               rit_on,
    input  logic [FREQ_W-1:0]  dial_freq,
    input  logic [FREQ_W-1:0]  tx_hold_freq,
    input  logic [PITCH_W-1:0] cw_pitch,
    input  logic               sidetone_opt,
    input  logic               load_done,
    output logic               load_req,
    output logic [FREQ_W-1:0]  load_freq,
    output logic               load_phase_270,
    output logic               tx_out,
    output logic               sidetone_en
);
    seq_state_t        state_q, state_nx;
    logic              key_lvl;
    logic              start_load;
    logic [FREQ_W-1:0] pick_freq;
    logic              pick_phase;
    logic [FREQ_W-1:0] freq_q;
    logic              phase_q;

    key_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_in  (key_raw),
        .key_lvl (key_lvl)
    );

    freq_pick #(.FREQ_W(FREQ_W), .PITCH_W(PITCH_W)) u_pick (
        .want_tx      (state_nx == ST_TX_LOAD),
        .cw_mode      (cw_mode),
        .upper_sb     (upper_sb),
        .rit_on       (rit_on),
        .dial_freq    (dial_freq),
        .tx_hold_freq (tx_hold_freq),
        .cw_pitch     (cw_pitch),
        .freq         (pick_freq),
        .phase_270    (pick_phase)
    );

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_RX_IDLE: if (key_lvl)   state_nx = ST_TX_LOAD;
            ST_TX_LOAD: if (load_done) state_nx = key_lvl ? ST_TX_ON : ST_UNKEY;
            ST_TX_ON:   if (!key_lvl)  state_nx = ST_UNKEY;
            ST_UNKEY:                  state_nx = ST_RX_LOAD;
            ST_RX_LOAD: if (load_done) state_nx = ST_RX_IDLE;
            default:                   state_nx = ST_RX_IDLE;
        endcase
    end

    assign start_load = (state_nx != state_q) &&
                        ((state_nx == ST_TX_LOAD) || (state_nx == ST_RX_LOAD));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RX_IDLE;
            freq_q  <= '0;
            phase_q <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (start_load) begin
                freq_q  <= pick_freq;
                phase_q <= pick_phase;
            end
        end
    end

    always_comb begin
        load_req       = (state_q == ST_TX_LOAD) || (state_q == ST_RX_LOAD);
        tx_out         = (state_q == ST_TX_ON);
        load_freq      = freq_q;
        load_phase_270 = phase_q;
        sidetone_en    = key_lvl & sidetone_opt;
    end
endmodule

// File: rtl/txrx_key_seq_chk.sv
module txrx_key_seq_chk #(
    parameter int FREQ_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_done,
    input logic              load_req,
    input logic [FREQ_W-1:0] load_freq,
    input logic              load_phase_270,
    input logic              tx_out,
    input logic              sidetone_en,
    input logic              sidetone_opt
);
    p_tx_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_out) |-> $past(load_req && load_done));

    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_out && load_req));

    p_drop_then_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_out) |-> (!load_req ##1 load_req));

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !load_done) |=> (load_req && $stable(load_freq) && $stable(load_phase_270)));

    p_req_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && load_done) |=> !load_req);

    p_sidetone_opt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sidetone_en |-> sidetone_opt);
endmodule

bind txrx_key_seq txrx_key_seq_chk #(.FREQ_W(FREQ_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .load_done      (load_done),
    .load_req       (load_req),
    .load_freq      (load_freq),
    .load_phase_270 (load_phase_270),
    .tx_out         (tx_out),
    .sidetone_en    (sidetone_en),
    .sidetone_opt   (sidetone_opt)
);

// File: tb/txrx_key_seq_test.sv
`timescale 1ns/1ps
module txrx_key_seq_test;
    localparam int FW  = 16;
    localparam int PW  = 10;
    localparam int DEB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          key_raw = 1'b0, cw_mode = 1'b0, upper_sb = 1'b0, rit_on = 1'b0;
    logic [FW-1:0] dial_freq = '0, tx_hold_freq = '0;
    logic [PW-1:0] cw_pitch = '0;
    logic          sidetone_opt = 1'b0, load_done = 1'b0;
    logic          load_req, load_phase_270, tx_out, sidetone_en;
    logic [FW-1:0] load_freq;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    txrx_key_seq #(.FREQ_W(FW), .PITCH_W(PW), .DEB_CYCLES(DEB)) uut (
        .clk(clk), .rst_n(rst_n), .key_raw(key_raw), .cw_mode(cw_mode),
        .upper_sb(upper_sb), .rit_on(rit_on), .dial_freq(dial_freq),
        .tx_hold_freq(tx_hold_freq), .cw_pitch(cw_pitch),
        .sidetone_opt(sidetone_opt), .load_done(load_done),
        .load_req(load_req), .load_freq(load_freq),
        .load_phase_270(load_phase_270), .tx_out(tx_out),
        .sidetone_en(sidetone_en)
    );

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            mismatched++;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
            report();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic wait_req(input string req);
        int n = 0;
        while (!load_req && n < 40) begin step(); n++; end
        chk(load_req, req, load_req, 1);
    endtask

    task automatic wait_tx_low(input string req);
        int n = 0;
        while (tx_out && n < 40) begin step(); n++; end
        chk(!tx_out, req, tx_out, 0);
    endtask

    task automatic pulse_done();
        load_done = 1'b1; step(); load_done = 1'b0;
    endtask

    function automatic logic [FW-1:0] exp_tx(input bit cw, input bit usb, input bit rit,
                                             input logic [FW-1:0] d, input logic [FW-1:0] h,
                                             input logic [PW-1:0] p);
        logic [FW-1:0] b;
        b = rit ? h : d;
        if (!cw) return b;
        return usb ? b + FW'(p) : b - FW'(p);
    endfunction

    initial begin
        logic [FW-1:0] e;
        step(); step();
        chk(!tx_out && !load_req && !sidetone_en, "R1", {tx_out, load_req, sidetone_en}, 0);
        rst_n = 1'b1;
        step();
        chk(!tx_out && !load_req && !sidetone_en, "R1", {tx_out, load_req, sidetone_en}, 0);

        // R9: a short glitch is ignored
        sidetone_opt = 1'b1;
        key_raw = 1'b1; step(); step(); key_raw = 1'b0;
        repeat (12) begin
            step();
            chk(!load_req && !sidetone_en, "R9", {load_req, sidetone_en}, 0);
        end

        // sweep over mode, sideband, RIT and frequencies with wrap
        for (int fs = 0; fs < 3; fs++) begin
            for (int cfg = 0; cfg < 8; cfg++) begin
                cw_mode  = cfg[0];
                upper_sb = cfg[1];
                rit_on   = cfg[2];
                sidetone_opt = cfg[0] ^ cfg[1];
                case (fs)
                    0: begin dial_freq = 16'h1234; tx_hold_freq = 16'h4000; cw_pitch = 10'd700; end
                    1: begin dial_freq = 16'h0100; tx_hold_freq = 16'h0050; cw_pitch = 10'h3FF; end
                    default: begin dial_freq = 16'hFF80; tx_hold_freq = 16'hFFF0; cw_pitch = 10'h200; end
                endcase
                e = exp_tx(cw_mode, upper_sb, rit_on, dial_freq, tx_hold_freq, cw_pitch);

                key_raw = 1'b1;
                wait_req("R2");
                chk(load_freq == e, "R4 R5 R7 tx freq", load_freq, e);
                chk(load_phase_270 == !upper_sb, "R6", load_phase_270, !upper_sb);
                repeat (3) begin
                    step();
                    chk(!tx_out && load_req && load_freq == e, "R2 R11 hold", {tx_out, load_req}, 1);
                end
                pulse_done();
                chk(tx_out && !load_req, "R2 tx after done", {tx_out, load_req}, 2);
                chk(sidetone_en == sidetone_opt, "R8", sidetone_en, sidetone_opt);

                key_raw = 1'b0;
                wait_tx_low("R3");
                chk(!load_req, "R3 drop first", load_req, 0);
                step();
                chk(load_req && load_freq == dial_freq, "R3 R7 rx load", load_freq, dial_freq);
                chk(!sidetone_en, "R8 key open", sidetone_en, 0);
                pulse_done();
                chk(!load_req && !tx_out, "R11 release", {tx_out, load_req}, 0);
                repeat (3) step();
            end
        end

        // R10: release during a transmit load, close during a receive load
        cw_mode = 1'b0; rit_on = 1'b0; dial_freq = 16'h2222;
        key_raw = 1'b1;
        wait_req("R10");
        key_raw = 1'b0;
        repeat (10) step();
        chk(load_req && !tx_out, "R10 pending tx", {tx_out, load_req}, 1);
        pulse_done();
        chk(!tx_out && !load_req, "R10 unkey", {tx_out, load_req}, 0);
        step();
        chk(load_req && !tx_out && load_freq == 16'h2222, "R10 rx load", load_freq, 16'h2222);
        key_raw = 1'b1;
        repeat (10) step();
        chk(load_req && !tx_out, "R10 pending rx", {tx_out, load_req}, 1);
        pulse_done();
        chk(!load_req && !tx_out, "R10 idle gap", {tx_out, load_req}, 0);
        step();
        chk(load_req && !tx_out, "R10 tx load", {tx_out, load_req}, 1);
        pulse_done();
        chk(tx_out, "R10 tx on", tx_out, 1);
        key_raw = 1'b0;
        wait_tx_low("R10 end");
        step();
        pulse_done();
        chk(!load_req && !tx_out, "R10 final", {tx_out, load_req}, 0);

        report();
    end
endmodule